// File: doc/BRIEF.md
# In-Order Issue Hazard Scoreboard

This block decides, once per cycle, whether the decoded instruction waiting at the head of an in-order pipeline may be dispatched. The instruction names an execution class (integer, floating add, floating multiply or floating divide), one destination register and two source registers. The block holds one pending-write flag per architectural register. It takes a busy flag from each execution class and stalls the instruction when its class is busy, when either source still awaits a result (read-after-write), or when its destination still awaits an earlier write (write-after-write).

Operands are read at issue and issue never reorders, so a younger instruction can never overwrite a register before an older one has read it. For that reason no write-after-read check exists. Decode offers an instruction with a valid/ready handshake and holds it while it is stalled, so the stall also blocks every younger instruction. The writeback stage reports each register it writes, and the block then clears that register's pending flag.

Top module: `issue_scoreboard`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), every pending flag is zero and no issue takes place while dec_valid is low.
- R2: issue_valid is high exactly when dec_valid and dec_ready are both high. While it is high, issue_fu and issue_dst equal dec_fu and dec_dst. The class encoding is 0 integer, 1 floating add, 2 floating multiply, 3 floating divide, and bit k of fu_busy belongs to class k.
- R3: dec_ready is low while fu_busy bit dec_fu is high.
- R4: An issue to register d makes pend_vec bit d high from the next cycle on.
- R5: A writeback (wb_valid high) of register r makes pend_vec bit r low from the next cycle on, unless the same cycle issues a write to r, in which case the bit stays high.
- R6: dec_ready is low while the pending flag of dec_src1 or of dec_src2 is high.
- R7: dec_ready is low while the pending flag of dec_dst is high.
- R8: A destination that is only a source of an older issued instruction does not stall issue.
- R9: The decision uses the flags as registered at the clock edge. A writeback in cycle n unblocks a stalled instruction from cycle n+1 on, not in cycle n.
- R10: While dec_valid is low, nothing is issued and no pending flag is set.
- R11: An issue and a writeback of two different registers in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decode offers an instruction |
| dec_ready | output | 1 | Offered instruction has no hazard |
| dec_fu | input | 2 | Execution class of the instruction |
| dec_dst | input | 5 | Destination register |
| dec_src1 | input | 5 | First source register |
| dec_src2 | input | 5 | Second source register |
| fu_busy | input | 4 | Busy flag per execution class |
| wb_valid | input | 1 | Writeback completes this cycle |
| wb_reg | input | 5 | Register written back |
| issue_valid | output | 1 | Instruction dispatched this cycle |
| issue_fu | output | 2 | Class of the dispatched instruction |
| issue_dst | output | 5 | Destination of the dispatched instruction |
| pend_vec | output | 32 | Pending-write flag per register |

## Verification
The assertions assume that a writeback only names a register whose flag is pending. Under that assumption a writeback and an issue can never target the same register in one cycle, because the write-after-write check refuses the issue. The bench only writes back registers that its own model holds as pending, and it retries a stalled instruction unchanged until the instruction dispatches, as decode would. The same-register priority of R5 is therefore built into the flag logic and covered by its assertion form, not driven by the stimulus.

// File: rtl/sb_pkg.sv
// Shared definitions for the issue scoreboard.
// Assumes four execution classes; the encoding doubles as the fu_busy bit index.
package sb_pkg;
    typedef enum logic [1:0] {
        FU_INT  = 2'd0,
        FU_FADD = 2'd1,
        FU_FMUL = 2'd2,
        FU_FDIV = 2'd3
    } fu_class_e;

    localparam int FU_CLASSES = 4;
endpackage

// File: rtl/sb_pend_table.sv
// Pending-write flag table: one flag per architectural register.
// Assumes at most one set and one clear per cycle; a set wins over a clear
// of the same register, so a write issued in the clear cycle stays pending.
module sb_pend_table #(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [IDX_W-1:0]    set_idx,
    input  logic                clr_en,
    input  logic [IDX_W-1:0]    clr_idx,
    output logic [NUM_REGS-1:0] pend_q
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flag
        // Update one register's flag: reset, then set, then clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[g] <= 1'b0;
            end else if (set_en && (set_idx == IDX_W'(g))) begin
                pend_q[g] <= 1'b1;
            end else if (clr_en && (clr_idx == IDX_W'(g))) begin
                pend_q[g] <= 1'b0;
            end
        end
    end

    // R4: a set is visible in the following cycle.
    p_set_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> pend_q[$past(set_idx)]);

    // R5: a clear without a competing set of the same register takes effect.
    p_clear_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && (set_idx == clr_idx))) |=> !pend_q[$past(clr_idx)]);

    // R5: a set in the clear cycle keeps the flag pending.
    p_set_beats_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && set_en && (set_idx == clr_idx)) |=> pend_q[$past(clr_idx)]);

endmodule

// File: rtl/sb_hazard_check.sv
// Combinational hazard detector for the instruction offered by decode.
// Assumes registered flag and busy inputs; performs no write-after-read check
// because operands are read at issue and issue is in order.
module sb_hazard_check #(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = $clog2(NUM_REGS),
    parameter int NUM_FU   = 4,
    parameter int FU_W     = $clog2(NUM_FU)
) (
    input  logic [NUM_REGS-1:0] pend,
    input  logic [NUM_FU-1:0]   fu_busy,
    input  logic [FU_W-1:0]     fu,
    input  logic [IDX_W-1:0]    dst,
    input  logic [IDX_W-1:0]    src1,
    input  logic [IDX_W-1:0]    src2,
    output logic                fu_stall,
    output logic                raw_stall,
    output logic                waw_stall,
    output logic                ok
);

    // Classify each stall cause and combine them into one go signal.
    always_comb begin
        fu_stall  = fu_busy[fu];
        raw_stall = pend[src1] || pend[src2];
        waw_stall = pend[dst];
        ok        = !(fu_stall || raw_stall || waw_stall);
    end

endmodule

// File: rtl/issue_scoreboard.sv
// In-order issue scoreboard: dispatches at most one decoded instruction per
// cycle when its class is free and no read-after-write or write-after-write
// hazard exists. Assumes writebacks only name pending registers and that
// decode holds a stalled instruction stable until it issues.
module issue_scoreboard
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int NUM_FU   = FU_CLASSES,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int FU_W    = $clog2(NUM_FU)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dec_valid,
    output logic                dec_ready,
    input  logic [FU_W-1:0]     dec_fu,
    input  logic [IDX_W-1:0]    dec_dst,
    input  logic [IDX_W-1:0]    dec_src1,
    input  logic [IDX_W-1:0]    dec_src2,
    input  logic [NUM_FU-1:0]   fu_busy,
    input  logic                wb_valid,
    input  logic [IDX_W-1:0]    wb_reg,
    output logic                issue_valid,
    output logic [FU_W-1:0]     issue_fu,
    output logic [IDX_W-1:0]    issue_dst,
    output logic [NUM_REGS-1:0] pend_vec
);

    logic fu_stall;
    logic raw_stall;
    logic waw_stall;
    logic go;
    logic fire;

    sb_hazard_check #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .NUM_FU   (NUM_FU),
        .FU_W     (FU_W)
    ) u_hazard (
        .pend      (pend_vec),
        .fu_busy   (fu_busy),
        .fu        (dec_fu),
        .dst       (dec_dst),
        .src1      (dec_src1),
        .src2      (dec_src2),
        .fu_stall  (fu_stall),
        .raw_stall (raw_stall),
        .waw_stall (waw_stall),
        .ok        (go)
    );

    // Handshake with decode and the dispatch outputs.
    always_comb begin
        dec_ready   = go;
        fire        = dec_valid && go;
        issue_valid = fire;
        issue_fu    = dec_fu;
        issue_dst   = dec_dst;
    end

    sb_pend_table #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (fire),
        .set_idx (dec_dst),
        .clr_en  (wb_valid),
        .clr_idx (wb_reg),
        .pend_q  (pend_vec)
    );

    // R3: nothing dispatches into a busy class.
    p_no_busy_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !fu_busy[issue_fu]);

    // R6: both sources are free of pending writes at dispatch.
    p_no_raw_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !(pend_vec[dec_src1] || pend_vec[dec_src2]));

    // R7: the destination is free of a pending write at dispatch.
    p_no_waw_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !pend_vec[issue_dst]);

    // R10: an idle cycle without writeback leaves the flags unchanged.
    p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_valid && !wb_valid) |=> $stable(pend_vec));

    // Input assumption: writebacks only name pending registers.
    p_wb_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> pend_vec[wb_reg]);

endmodule

// File: tb/issue_scoreboard_bench.sv
module issue_scoreboard_bench;

    localparam int NREG = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic        dec_ready;
    logic [1:0]  dec_fu = '0;
    logic [4:0]  dec_dst = '0;
    logic [4:0]  dec_src1 = '0;
    logic [4:0]  dec_src2 = '0;
    logic [3:0]  fu_busy = '0;
    logic        wb_valid = 1'b0;
    logic [4:0]  wb_reg = '0;
    logic        issue_valid;
    logic [1:0]  issue_fu;
    logic [4:0]  issue_dst;
    logic [NREG-1:0] pend_vec;

    always #2.5 clk = ~clk;

    issue_scoreboard u_issue_scoreboard (
        .clk (clk), .rst_n (rst_n),
        .dec_valid (dec_valid), .dec_ready (dec_ready),
        .dec_fu (dec_fu), .dec_dst (dec_dst),
        .dec_src1 (dec_src1), .dec_src2 (dec_src2),
        .fu_busy (fu_busy), .wb_valid (wb_valid), .wb_reg (wb_reg),
        .issue_valid (issue_valid), .issue_fu (issue_fu),
        .issue_dst (issue_dst), .pend_vec (pend_vec)
    );

    typedef struct {
        bit              fire;
        bit              valid;
        logic [1:0]      fu;
        logic [4:0]      dst;
        logic [NREG-1:0] pend;
        string           tag;
    } exp_t;

    exp_t            expq[$];
    logic [NREG-1:0] model = '0;
    int              tests = 0;
    int              fails = 0;
    bit              done = 1'b0;

    // Driver: apply one cycle of stimulus and queue the expected outcome.
    task automatic step(input bit v, input logic [1:0] f, input int d,
                        input int s1, input int s2, input logic [3:0] busy,
                        input bit wv, input int wr, input string tag);
        exp_t e;
        logic [NREG-1:0] nxt;
        @(negedge clk);
        dec_valid = v; dec_fu = f; dec_dst = 5'(d);
        dec_src1 = 5'(s1); dec_src2 = 5'(s2);
        fu_busy = busy; wb_valid = wv; wb_reg = 5'(wr);
        e.valid = v;
        e.fire  = v && !busy[f] && !model[s1] && !model[s2] && !model[d];
        e.fu    = f;
        e.dst   = 5'(d);
        e.pend  = model;
        e.tag   = tag;
        expq.push_back(e);
        nxt = model;
        if (wv) nxt[wr] = 1'b0;
        if (e.fire) nxt[d] = 1'b1;
        model = nxt;
    endtask

    // Monitor: compare the design's outputs before each rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                tests++;
                if (issue_valid !== e.fire) begin
                    fails++;
                    $display("FAIL %s issue_valid actual %0b expected %0b", e.tag, issue_valid, e.fire);
                end
                if (e.valid) begin
                    tests++;
                    if (dec_ready !== e.fire) begin
                        fails++;
                        $display("FAIL %s dec_ready actual %0b expected %0b", e.tag, dec_ready, e.fire);
                    end
                end
                if (e.fire) begin
                    tests++;
                    if (issue_fu !== e.fu || issue_dst !== e.dst) begin
                        fails++;
                        $display("FAIL R2 issue fields actual %0d/%0d expected %0d/%0d",
                                 issue_fu, issue_dst, e.fu, e.dst);
                    end
                end
                tests++;
                if (pend_vec !== e.pend) begin
                    fails++;
                    $display("FAIL %s pend_vec actual %h expected %h", e.tag, pend_vec, e.pend);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #100000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: flags clear after reset, nothing issues.
        step(0, 2'd0, 0, 0, 0, 4'b0000, 0, 0, "R1");
        // R2: plain integer issue.
        step(1, 2'd0, 1, 2, 3, 4'b0000, 0, 0, "R2");
        // R4: destination flag now visible.
        step(0, 2'd0, 0, 0, 0, 4'b0000, 0, 0, "R4");
        // R6: first source pending.
        step(1, 2'd1, 4, 1, 0, 4'b0000, 0, 0, "R6");
        // R9: writeback of the source in this cycle does not unblock yet.
        step(1, 2'd1, 4, 1, 0, 4'b0000, 1, 1, "R9");
        // R5: cleared flag lets the held instruction go.
        step(1, 2'd1, 4, 1, 0, 4'b0000, 0, 0, "R5");
        // R7: destination still pending.
        step(1, 2'd0, 4, 0, 0, 4'b0000, 0, 0, "R7");
        // R3: multiply class busy while destination 4 is written back.
        step(1, 2'd2, 5, 0, 0, 4'b0100, 1, 4, "R3");
        // R3: class released, instruction goes.
        step(1, 2'd2, 5, 0, 0, 4'b0000, 0, 0, "R3");
        // R3: busy flag of another class is irrelevant.
        step(1, 2'd0, 6, 0, 0, 4'b1110, 0, 0, "R3");
        // R6: second source pending.
        step(1, 2'd3, 7, 0, 5, 4'b0000, 0, 0, "R6");
        step(1, 2'd3, 7, 0, 5, 4'b0000, 1, 5, "R9");
        step(1, 2'd3, 7, 0, 5, 4'b0000, 0, 0, "R6");
        // R11: issue of 9 with writeback of 7 in the same cycle.
        step(1, 2'd0, 9, 0, 0, 4'b0000, 1, 7, "R11");
        // R8: older instruction reads 11, younger writes 11.
        step(1, 2'd1, 10, 11, 12, 4'b0000, 0, 0, "R8");
        step(1, 2'd0, 11, 0, 0, 4'b0000, 0, 0, "R8");
        // R10: invalid offer neither issues nor sets a flag.
        step(0, 2'd0, 12, 0, 0, 4'b0000, 0, 0, "R10");
        step(0, 2'd0, 0, 0, 0, 4'b0000, 0, 0, "R10");
        // R7: highest register index.
        step(1, 2'd0, 31, 0, 0, 4'b0000, 0, 0, "R2");
        step(1, 2'd3, 31, 2, 3, 4'b0000, 0, 0, "R7");
        // R5: drain and observe cleared flags.
        step(0, 2'd0, 0, 0, 0, 4'b0000, 1, 31, "R5");
        step(0, 2'd0, 0, 0, 0, 4'b0000, 1, 6, "R5");
        step(0, 2'd0, 0, 0, 0, 4'b0000, 0, 0, "R5");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule